// File: doc/BRIEF.md
# Reference Frequency Offset Monitor

This block decides whether an incoming reference clock runs close enough to its nominal rate to be trusted. A local master clock drives everything. The block brings the reference into that domain and counts its rising edges over a fixed gate of master-clock cycles. At the end of each gate it compares the count against the nominal edge count and reports the signed difference. The master clock is the yardstick, so any error in the master clock appears one-for-one in the reported offset.

Qualification uses two bounds. An offset of at most the accept bound marks the reference good. An offset beyond the wider reject bound marks it bad. An offset between the two bounds leaves the previous verdict in place, which keeps the flag from chattering near a limit. Both bounds are set in parts per billion and are converted to edge counts when the block is built.

With the default parameters a 20 MHz master clock times a 10 s gate, and the bounds are 9.2 ppm to accept and 12 ppm to reject. A system reads `ref_valid` before it lets a loop lock to the reference.

Top module: `ref_freq_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ref_valid`, `meas_done` and `offset_edges` are all zero.
- R2: `ref_in` passes through a two-flop synchroniser before edge detection. Each low-to-high transition seen in the master domain counts once, in the gate during which it arrives.
- R3: `meas_done` is high for exactly one cycle in every GATE_CYCLES master cycles. It first rises GATE_CYCLES cycles after reset is released.
- R4: When `meas_done` rises, `offset_edges` takes the value (edges counted in the gate just ended) minus NOMINAL_EDGES. The value is two's complement, CNT_W+1 bits wide, where CNT_W = clog2(GATE_CYCLES+1).
- R5: When `meas_done` rises and |offset| <= floor(NOMINAL_EDGES*ACCEPT_PPB/1e9), `ref_valid` becomes 1.
- R6: When `meas_done` rises and |offset| > floor(NOMINAL_EDGES*REJECT_PPB/1e9), `ref_valid` becomes 0.
- R7: When `meas_done` rises and |offset| lies above the accept bound but not above the reject bound, `ref_valid` keeps its previous value.
- R8: `ref_valid` stays 0 until the first gate has been evaluated.
- R9: `ref_valid` and `offset_edges` change only in cycles where `meas_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock under test, asynchronous to clk |
| meas_done | output | 1 | One-cycle pulse when a new measurement is published |
| ref_valid | output | 1 | Reference lies inside the acceptance window |
| offset_edges | output | CNT_W+1 | Signed edge-count offset from the last gate |

## Verification
The assertions run on every cycle. They check the fixed spacing of the publish pulse, that the outputs stay still between pulses, and that the flag stays low before the first verdict. They also check that each verdict obeys the accept, reject and hold rules against the offset published with it.

The assertions cannot show that the offset is the right number. Only the bench scenarios can. The bench drives square waves with known edge counts per gate and checks the results against a behavioural model. These scenarios step through both exact bound values, both signs of offset and a stuck reference, and they approach the hysteresis band from each side.

// File: rtl/ref_freq_monitor_pkg.sv
package ref_freq_monitor_pkg;

  typedef enum logic [1:0] {
    VERDICT_HOLD   = 2'd0,
    VERDICT_ACCEPT = 2'd1,
    VERDICT_REJECT = 2'd2
  } verdict_e;

  // Convert a parts-per-billion tolerance into an edge-count tolerance.
  function automatic longint ppb_to_edges(input longint nominal, input longint ppb);
    return (nominal * ppb) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/rfm_sync_edge.sv
module rfm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  // Edge between the last synchroniser stage and one extra history flop.
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rfm_gate_timer.sv
module rfm_gate_timer #(
  parameter int GATE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic gate_last
);
  localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

  logic [GW-1:0] tick;

  always_ff @(posedge clk) begin
    if (rst)             tick <= '0;
    else if (tick == LAST) tick <= '0;
    else                 tick <= tick + 1'b1;
  end

  assign gate_last = (tick == LAST);
endmodule

// File: rtl/rfm_edge_counter.sv
module rfm_edge_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             gate_last,
  output logic [CNT_W-1:0] count_lat,
  output logic             load
);
  logic [CNT_W-1:0] run;
  logic [CNT_W-1:0] run_next;

  assign run_next = run + CNT_W'(rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= '0;
      count_lat <= '0;
      load      <= 1'b0;
    end else if (gate_last) begin
      count_lat <= run_next;
      run       <= '0;
      load      <= 1'b1;
    end else begin
      run       <= run_next;
      load      <= 1'b0;
    end
  end
endmodule

// File: rtl/rfm_qualifier.sv
module rfm_qualifier
  import ref_freq_monitor_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int NOMINAL   = 100,
  parameter int ACC_EDGES = 2,
  parameter int REJ_EDGES = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [CNT_W-1:0]        count_lat,
  output logic                    done,
  output logic                    valid,
  output logic signed [CNT_W:0]   offset
);
  logic signed [CNT_W:0] diff;
  logic        [CNT_W:0] mag;
  verdict_e              verdict;

  assign diff = $signed({1'b0, count_lat}) - $signed((CNT_W+1)'(NOMINAL));
  assign mag  = diff[CNT_W] ? (CNT_W+1)'(-diff) : (CNT_W+1)'(diff);

  always_comb begin
    if (mag <= (CNT_W+1)'(ACC_EDGES))      verdict = VERDICT_ACCEPT;
    else if (mag > (CNT_W+1)'(REJ_EDGES))  verdict = VERDICT_REJECT;
    else                                   verdict = VERDICT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      valid  <= 1'b0;
      offset <= '0;
    end else begin
      done <= load;
      if (load) begin
        offset <= diff;
        case (verdict)
          VERDICT_ACCEPT: valid <= 1'b1;
          VERDICT_REJECT: valid <= 1'b0;
          default:        valid <= valid;
        endcase
      end
    end
  end
endmodule

// File: rtl/ref_freq_monitor.sv
module ref_freq_monitor
  import ref_freq_monitor_pkg::*;
#(
  parameter int GATE_CYCLES   = 200_000_000,
  parameter int NOMINAL_EDGES = 20_480_000,
  parameter int ACCEPT_PPB    = 9_200,
  parameter int REJECT_PPB    = 12_000
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      ref_in,
  output logic                                      meas_done,
  output logic                                      ref_valid,
  output logic signed [$clog2(GATE_CYCLES+1):0]     offset_edges
);
  localparam int CNT_W     = $clog2(GATE_CYCLES + 1);
  localparam int ACC_EDGES = int'(ppb_to_edges(longint'(NOMINAL_EDGES), longint'(ACCEPT_PPB)));
  localparam int REJ_EDGES = int'(ppb_to_edges(longint'(NOMINAL_EDGES), longint'(REJECT_PPB)));

  logic             rise;
  logic             gate_last;
  logic             load;
  logic [CNT_W-1:0] count_lat;

  rfm_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_in(ref_in), .rise(rise)
  );

  rfm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk(clk), .rst(rst), .gate_last(gate_last)
  );

  rfm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .gate_last(gate_last),
    .count_lat(count_lat), .load(load)
  );

  rfm_qualifier #(
    .CNT_W(CNT_W), .NOMINAL(NOMINAL_EDGES),
    .ACC_EDGES(ACC_EDGES), .REJ_EDGES(REJ_EDGES)
  ) u_qual (
    .clk(clk), .rst(rst), .load(load), .count_lat(count_lat),
    .done(meas_done), .valid(ref_valid), .offset(offset_edges)
  );
endmodule

// File: rtl/ref_freq_monitor_checker.sv
module ref_freq_monitor_checker #(
  parameter int GATE_CYCLES   = 1000,
  parameter int NOMINAL_EDGES = 100,
  parameter int ACCEPT_PPB    = 0,
  parameter int REJECT_PPB    = 0
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  meas_done,
  input logic                                  ref_valid,
  input logic signed [$clog2(GATE_CYCLES+1):0] offset_edges
);
  localparam int OW  = $clog2(GATE_CYCLES + 1) + 1;
  localparam longint ACC = (longint'(NOMINAL_EDGES) * longint'(ACCEPT_PPB)) / 64'd1_000_000_000;
  localparam longint REJ = (longint'(NOMINAL_EDGES) * longint'(REJECT_PPB)) / 64'd1_000_000_000;

  int unsigned phase;
  logic        wrapped;
  logic        seen;
  longint      mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= 0;
      wrapped <= 1'b0;
      seen    <= 1'b0;
    end else begin
      phase <= (phase == GATE_CYCLES - 1) ? 0 : phase + 1;
      if (phase == GATE_CYCLES - 1) wrapped <= 1'b1;
      if (meas_done) seen <= 1'b1;
    end
  end

  always_comb mag = (offset_edges < 0) ? -longint'(offset_edges) : longint'(offset_edges);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ref_valid && !meas_done && offset_edges == '0));

  p_done_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    meas_done |-> (phase == 1 && wrapped));

  p_done_present_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == 1 && wrapped) |-> meas_done);

  p_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (meas_done && mag <= ACC) |-> ref_valid);

  p_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (meas_done && mag > REJ) |-> !ref_valid);

  p_hold_band_r7: assert property (@(posedge clk) disable iff (rst)
    (meas_done && mag > ACC && mag <= REJ) |-> (ref_valid == $past(ref_valid)));

  p_low_first_r8: assert property (@(posedge clk) disable iff (rst)
    (!seen && !meas_done) |-> !ref_valid);

  p_quiet_between_r9: assert property (@(posedge clk) disable iff (rst)
    !meas_done |-> ($stable(ref_valid) && $stable(offset_edges)));

  initial assert (OW >= 2);
endmodule

bind ref_freq_monitor ref_freq_monitor_checker #(
  .GATE_CYCLES(GATE_CYCLES), .NOMINAL_EDGES(NOMINAL_EDGES),
  .ACCEPT_PPB(ACCEPT_PPB), .REJECT_PPB(REJECT_PPB)
) u_chk (
  .clk(clk), .rst(rst), .meas_done(meas_done),
  .ref_valid(ref_valid), .offset_edges(offset_edges)
);

// File: tb/ref_freq_monitor_bench.sv
module ref_freq_monitor_bench;
  localparam int G   = 1000;
  localparam int NOM = 100;
  localparam int ACC = 2;   // 20,000,000 ppb of 100 edges
  localparam int REJ = 5;   // 50,000,000 ppb of 100 edges
  localparam int OW  = $clog2(G + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic meas_done;
  logic ref_valid;
  logic signed [OW-1:0] offset_edges;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int n_edges = NOM;
  bit finished = 0;

  always #5 clk = ~clk;

  ref_freq_monitor #(
    .GATE_CYCLES(G), .NOMINAL_EDGES(NOM),
    .ACCEPT_PPB(20_000_000), .REJECT_PPB(50_000_000)
  ) u_ref_freq_monitor (
    .clk(clk), .rst(rst), .ref_in(ref_in),
    .meas_done(meas_done), .ref_valid(ref_valid), .offset_edges(offset_edges)
  );

  // Behavioural model: history queue of sampled reference, edge bins per gate.
  int  hist[$];
  int  m_run, m_lat, m_off, j;
  bit  m_pend, m_done, m_valid;

  always @(posedge clk) begin
    if (rst) begin
      hist = {}; m_run = 0; m_lat = 0; m_off = 0; j = 0;
      m_pend = 0; m_done = 0; m_valid = 0;
    end else begin
      int r2, r3, rs, mag;
      m_done = m_pend;
      if (m_pend) begin
        m_off = m_lat - NOM;
        mag = (m_off < 0) ? -m_off : m_off;
        if (mag <= ACC) m_valid = 1;
        else if (mag > REJ) m_valid = 0;
      end
      r2 = (hist.size() >= 2) ? hist[hist.size()-2] : 0;
      r3 = (hist.size() >= 3) ? hist[hist.size()-3] : 0;
      rs = (r2 == 1 && r3 == 0) ? 1 : 0;
      if (j % G == G - 1) begin
        m_lat = m_run + rs; m_run = 0; m_pend = 1;
      end else begin
        m_run = m_run + rs; m_pend = 0;
      end
      hist.push_back(int'(ref_in));
      if (hist.size() > 4) void'(hist.pop_front());
      j++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Compare against the model each cycle, then drive the next reference level.
  task automatic run_cycles(input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      check("R3 meas_done", int'(meas_done), int'(m_done));
      check("R7 ref_valid", int'(ref_valid), int'(m_valid));
      check("R4 offset_edges", int'(offset_edges), m_off);
      cyc++;
      ref_in = (((cyc * n_edges * 2) / G) % 2) == 1;
    end
  endtask

  task automatic scenario(input int n, input string tag, input int exp_v, input int exp_off);
    n_edges = n;
    run_cycles(3 * G);
    check({tag, " valid"}, int'(ref_valid), exp_v);
    check({"R4 offset for ", tag}, int'(offset_edges), exp_off);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid in reset", int'(ref_valid), 0);
    check("R1 done in reset", int'(meas_done), 0);
    check("R1 offset in reset", int'(offset_edges), 0);
    rst = 1'b0;
    // First gate: flag must stay low until the first publish (R8).
    run_cycles(G);
    check("R8 valid before first verdict", int'(ref_valid), 0);
    run_cycles(1);
    check("R3 first meas_done", int'(meas_done), 1);
    run_cycles(1);
    check("R3 meas_done one cycle", int'(meas_done), 0);
    scenario(100, "R5 nominal", 1, 0);
    scenario(102, "R5 at accept bound", 1, 2);
    scenario(104, "R7 band from good", 1, 4);
    scenario(106, "R6 beyond reject", 0, 6);
    scenario(104, "R7 band from bad", 0, 4);
    scenario(97,  "R7 negative band from bad", 0, -3);
    scenario(98,  "R5 negative accept bound", 1, -2);
    scenario(95,  "R7 negative reject bound holds", 1, -5);
    scenario(94,  "R6 negative beyond reject", 0, -6);
    scenario(101, "R2 edge count", 1, 1);
    scenario(0,   "R6 stuck reference", 0, -100);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(100_000 * 10);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule